// File: doc/BRIEF.md
# Interrupt Priority and Service Tracker

This block keeps the interrupt state of one local interrupt controller across 256 vectors: which vectors are waiting (pending), which the core is currently servicing (in service), and which arrived as level-triggered requests (trigger mode). Fixed or lowest-priority requests arrive as a vector plus a level/edge flag. A programmable task priority and the highest in-service vector together set the processor priority. The block offers the core the highest pending vector whose priority class is above that processor priority.

The core takes a vector with an acknowledge pulse, which moves it from pending to in service. It retires the vector with an end-of-interrupt command. When the retired vector was level-triggered, the block emits a one-cycle broadcast carrying the vector, so that the interrupt source can re-sample its line. A dedicated timer input raises a configurable timer vector. Timer firings that arrive while that vector is still pending are counted, and each acknowledge of the timer vector makes one of them pending again. Register decode, the timer itself and message routing between processors are handled elsewhere.

Top module: `irq_service_tracker`

## Requirements
- R1: The highest set vector is found by scanning eight 32-vector groups from the top group down. When no pending vector qualifies, `dlv_valid` is 0.
- R2: `ppr` equals the 8-bit task priority when its upper nibble is at least bits 7:4 of the highest in-service vector (taken as 0 when nothing is in service). Otherwise `ppr` equals that vector with bits 3:0 forced to zero.
- R3: `dlv_valid` is 1 only when the highest pending vector with bits 3:0 cleared is strictly greater than `ppr`. `dlv_vec` then carries that vector.
- R4: An `ack_valid` pulse sets the in-service bit of `ack_vec` and clears its pending bit in the same clock edge.
- R5: A level request (`req_level`=1) for a vector that is already pending is dropped. Any other level request sets both the pending bit and the trigger-mode bit. An edge request sets only the pending bit.
- R6: `eoi_cmd` clears the highest in-service bit. If that vector's trigger-mode bit was set, the trigger-mode bit is cleared and `eoi_bc_valid` pulses for one cycle with `eoi_bc_vec` holding the vector. With nothing in service the command does nothing.
- R7: A task-priority write keeps only bits 7:0 of `tpr_wdata`.
- R8: A `timer_fire` while `timer_vec` is pending increments a saturating counter. An acknowledge of `timer_vec` while the counter is non-zero decrements it and sets the pending bit again.
- R9: While `ctl_en` is 0, requests and timer firings change no state, and `dlv_valid` is 0.
- R10: When a request and an acknowledge name the same vector in one cycle, the request is applied after the acknowledge, so the vector remains pending and also becomes in service.
- R11: `ppr`, `dlv_valid` and `dlv_vec` are registered. They reflect a change of pending, in-service or task-priority state one cycle after the edge that made the change.
- R12: Synchronous reset clears all three bit arrays, the task priority and the timer counter, and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable; requests are ignored when low |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_vec | input | 8 | Vector being acknowledged |
| eoi_cmd | input | 1 | End-of-interrupt command strobe |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data (bits 7:0 kept) |
| timer_fire | input | 1 | Timer expiry strobe |
| timer_vec | input | 8 | Vector raised by the timer |
| ppr | output | 8 | Registered processor priority |
| dlv_valid | output | 1 | A deliverable vector exists |
| dlv_vec | output | 8 | Deliverable vector |
| eoi_bc_valid | output | 1 | One-cycle level-EOI broadcast pulse |
| eoi_bc_vec | output | 8 | Vector carried by the broadcast |

## Verification
The bench checks the strict comparison at the class boundary: a task priority equal to the pending class must block delivery, and a design using "greater or equal" would deliver. It checks a task-priority nibble equal to the in-service class, where an off-by-one rule would report the class instead of the full task priority. It runs nested service so that a wrong end-of-interrupt would retire the lower vector. It sends a level request to a vector already pending by edge, so that a design that still marks trigger mode produces an unexpected broadcast. It also checks that exactly two timer re-pends follow three coalesced firings, that requests made while disabled leave no trace, and that a same-cycle request and acknowledge leave the vector pending; a design that applies the acknowledge last loses that vector.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLS_W   = 4;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_hi_find.sv
module irq_hi_find #(
  parameter int NUM   = 256,
  parameter int GRP_W = 32
) (
  input  logic [NUM-1:0]         bits,
  output logic                   found,
  output logic [$clog2(NUM)-1:0] idx
);
  localparam int NGRP = NUM / GRP_W;
  localparam int IW   = $clog2(NUM);
  localparam int GW   = $clog2(GRP_W);

  logic [NGRP-1:0] grp_any;
  logic [GW-1:0]   grp_idx [NGRP];

  // per-group OR and local priority encoder
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GW-1:0] li;
    assign grp_any[g] = |bits[g*GRP_W +: GRP_W];
    always_comb begin
      li = '0;
      for (int b = 0; b < GRP_W; b++)
        if (bits[g*GRP_W + b]) li = GW'(b);
    end
    assign grp_idx[g] = li;
  end

  // highest non-empty group wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) begin
        found = 1'b1;
        idx   = IW'(g * GRP_W) | IW'(grp_idx[g]);
      end
    end
  end
endmodule

// File: rtl/irq_prio_calc.sv
module irq_prio_calc
  import irq_track_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic irr_found,
  input  vec_t irr_vec,
  input  logic isr_found,
  input  vec_t isr_vec,
  input  vec_t tpr,
  output vec_t ppr_q,
  output logic dlv_valid_q,
  output vec_t dlv_vec_q
);
  localparam int LO_W = VEC_W - CLS_W;

  vec_t isrv, ppr_c, irr_cls;
  logic dv_c;

  always_comb begin
    isrv    = isr_found ? isr_vec : '0;
    irr_cls = {irr_vec[VEC_W-1 -: CLS_W], {LO_W{1'b0}}};
    if (tpr[VEC_W-1 -: CLS_W] >= isrv[VEC_W-1 -: CLS_W])
      ppr_c = tpr;
    else
      ppr_c = {isrv[VEC_W-1 -: CLS_W], {LO_W{1'b0}}};
    dv_c = en && irr_found && (irr_cls > ppr_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ppr_q       <= '0;
      dlv_valid_q <= 1'b0;
      dlv_vec_q   <= '0;
    end else begin
      ppr_q       <= ppr_c;
      dlv_valid_q <= dv_c;
      dlv_vec_q   <= dv_c ? irr_vec : '0;
    end
  end

  // R3: offered vector's class is above the reported priority
  assert_dlv_above_ppr_R3: assert property (@(posedge clk) disable iff (rst)
    dlv_valid_q |-> ({dlv_vec_q[VEC_W-1 -: CLS_W], {LO_W{1'b0}}} > ppr_q));

  // R2: processor priority never drops below the task priority
  assert_ppr_not_below_tpr_R2: assert property (@(posedge clk) disable iff (rst)
    ppr_q >= $past(tpr));
endmodule

// File: rtl/irq_service_tracker.sv
module irq_service_tracker
  import irq_track_pkg::*;
#(
  parameter int GRP_W = 32,
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_en,
  input  logic        req_valid,
  input  logic [7:0]  req_vec,
  input  logic        req_level,
  input  logic        ack_valid,
  input  logic [7:0]  ack_vec,
  input  logic        eoi_cmd,
  input  logic        tpr_wr,
  input  logic [31:0] tpr_wdata,
  input  logic        timer_fire,
  input  logic [7:0]  timer_vec,
  output logic [7:0]  ppr,
  output logic        dlv_valid,
  output logic [7:0]  dlv_vec,
  output logic        eoi_bc_valid,
  output logic [7:0]  eoi_bc_vec
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q, irr_n, isr_n, tmr_n;
  vec_t               tpr_q, tpr_n, bc_vec_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               bc_v_n;
  logic               irr_found, isr_found;
  vec_t               irr_hi, isr_hi;

  irq_hi_find #(.NUM(NUM_VEC), .GRP_W(GRP_W)) u_irr_find (
    .bits(irr_q), .found(irr_found), .idx(irr_hi));
  irq_hi_find #(.NUM(NUM_VEC), .GRP_W(GRP_W)) u_isr_find (
    .bits(isr_q), .found(isr_found), .idx(isr_hi));

  // order inside one cycle: EOI, acknowledge, request, timer
  always_comb begin
    irr_n    = irr_q;
    isr_n    = isr_q;
    tmr_n    = tmr_q;
    cnt_n    = cnt_q;
    bc_v_n   = 1'b0;
    bc_vec_n = eoi_bc_vec;
    tpr_n    = tpr_wr ? tpr_wdata[7:0] : tpr_q;

    if (eoi_cmd && isr_found) begin
      isr_n[isr_hi] = 1'b0;
      if (tmr_q[isr_hi]) begin
        tmr_n[isr_hi] = 1'b0;
        bc_v_n        = 1'b1;
        bc_vec_n      = isr_hi;
      end
    end

    if (ack_valid) begin
      isr_n[ack_vec] = 1'b1;
      irr_n[ack_vec] = 1'b0;
      if (ack_vec == timer_vec && cnt_q != '0) begin
        cnt_n          = cnt_q - 1'b1;
        irr_n[ack_vec] = 1'b1;
      end
    end

    if (ctl_en && req_valid && !(req_level && irr_n[req_vec])) begin
      irr_n[req_vec] = 1'b1;
      if (req_level) tmr_n[req_vec] = 1'b1;
    end

    if (ctl_en && timer_fire) begin
      if (irr_n[timer_vec]) begin
        if (cnt_n != '1) cnt_n = cnt_n + 1'b1;
      end else begin
        irr_n[timer_vec] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q        <= '0;
      isr_q        <= '0;
      tmr_q        <= '0;
      tpr_q        <= '0;
      cnt_q        <= '0;
      eoi_bc_valid <= 1'b0;
      eoi_bc_vec   <= '0;
    end else begin
      irr_q        <= irr_n;
      isr_q        <= isr_n;
      tmr_q        <= tmr_n;
      tpr_q        <= tpr_n;
      cnt_q        <= cnt_n;
      eoi_bc_valid <= bc_v_n;
      eoi_bc_vec   <= bc_vec_n;
    end
  end

  irq_prio_calc u_prio (
    .clk(clk), .rst(rst), .en(ctl_en),
    .irr_found(irr_found), .irr_vec(irr_hi),
    .isr_found(isr_found), .isr_vec(isr_hi),
    .tpr(tpr_q),
    .ppr_q(ppr), .dlv_valid_q(dlv_valid), .dlv_vec_q(dlv_vec));

  // R4: an acknowledged vector is in service after the edge
  assert_ack_in_service_R4: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> isr_q[$past(ack_vec)]);

  // R9: no new pending bit appears while disabled
  assert_disabled_no_gain_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !ack_valid) |=> ((irr_q & ~$past(irr_q)) == '0));

  // R6: a broadcast only follows an end-of-interrupt command
  assert_bcast_after_eoi_R6: assert property (@(posedge clk) disable iff (rst)
    eoi_bc_valid |-> $past(eoi_cmd));

  // R5: an accepted level request marks trigger mode
  assert_level_sets_tmr_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_en && req_valid && req_level && !irr_q[req_vec] && !ack_valid)
      |=> tmr_q[$past(req_vec)]);
endmodule

// File: tb/irq_service_tracker_tb.sv
module irq_service_tracker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_en = 1'b0, req_valid = 1'b0, req_level = 1'b0;
  logic        ack_valid = 1'b0, eoi_cmd = 1'b0, tpr_wr = 1'b0, timer_fire = 1'b0;
  logic [7:0]  req_vec = '0, ack_vec = '0, timer_vec = 8'h50;
  logic [31:0] tpr_wdata = '0;
  logic [7:0]  ppr, dlv_vec, eoi_bc_vec;
  logic        dlv_valid, eoi_bc_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [7:0] bc_q [$];

  always #2 clk = ~clk;

  irq_service_tracker u_dut (
    .clk(clk), .rst(rst), .ctl_en(ctl_en),
    .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi_cmd(eoi_cmd),
    .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
    .timer_fire(timer_fire), .timer_vec(timer_vec),
    .ppr(ppr), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec),
    .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vec(eoi_bc_vec));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_dlv(input string tag, input logic v, input logic [7:0] vec);
    check({tag, " dlv_valid"}, {31'd0, dlv_valid}, {31'd0, v});
    if (v) check({tag, " dlv_vec"}, {24'd0, dlv_vec}, {24'd0, vec});
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_req(input logic [7:0] v, input logic lvl);
    req_valid = 1'b1; req_vec = v; req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_ack(input logic [7:0] v);
    ack_valid = 1'b1; ack_vec = v;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  // driver pushes the expected broadcast into the scoreboard
  task automatic do_eoi(input logic exp_bc, input logic [7:0] v);
    if (exp_bc) bc_q.push_back(v);
    eoi_cmd = 1'b1;
    @(negedge clk);
    eoi_cmd = 1'b0;
  endtask

  task automatic do_tpr(input logic [31:0] d);
    tpr_wr = 1'b1; tpr_wdata = d;
    @(negedge clk);
    tpr_wr = 1'b0;
  endtask

  task automatic do_fire();
    timer_fire = 1'b1;
    @(negedge clk);
    timer_fire = 1'b0;
  endtask

  // monitor: pops the scoreboard on each broadcast pulse
  always @(negedge clk) begin
    if (!rst && !done && eoi_bc_valid) begin
      n_checks++;
      if (bc_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 unexpected broadcast: actual %0h expected none", eoi_bc_vec);
      end else begin
        logic [7:0] e;
        e = bc_q.pop_front();
        if (eoi_bc_vec !== e) begin
          n_fail++;
          $display("FAIL R6 broadcast vector: actual %0h expected %0h", eoi_bc_vec, e);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0; ctl_en = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 ppr", {24'd0, ppr}, 32'h0);
    check("R12 dlv_valid", {31'd0, dlv_valid}, 32'h0);
    check("R12 eoi_bc_valid", {31'd0, eoi_bc_valid}, 32'h0);

    // R11 latency, R3 delivery
    do_req(8'h45, 1'b0);
    check_dlv("R11 one cycle after edge", 1'b0, 8'h00);
    settle();
    check_dlv("R11 R3 first pending", 1'b1, 8'h45);
    do_req(8'h32, 1'b0); settle();
    check_dlv("R1 lower vector does not win", 1'b1, 8'h45);
    do_req(8'hA1, 1'b0); settle();
    check_dlv("R1 higher group wins", 1'b1, 8'hA1);

    // R7 task priority byte, R3 strict compare
    do_tpr(32'hFFFF_FFB3); settle();
    check("R7 tpr keeps low byte", {24'd0, ppr}, 32'hB3);
    check_dlv("R3 blocked by tpr", 1'b0, 8'h00);
    do_tpr(32'h0000_00A0); settle();
    check_dlv("R3 equal class blocked", 1'b0, 8'h00);
    do_tpr(32'h0000_009F); settle();
    check_dlv("R3 class above tpr", 1'b1, 8'hA1);
    do_tpr(32'h0); settle();

    // R4 acknowledge, R2 priority from in-service
    do_ack(8'hA1); settle();
    check("R2 R4 ppr from in-service", {24'd0, ppr}, 32'hA0);
    check_dlv("R4 acked vector left pending", 1'b0, 8'h00);
    do_tpr(32'h0000_00C5); settle();
    check("R2 tpr above in-service", {24'd0, ppr}, 32'hC5);
    do_tpr(32'h0); settle();
    do_eoi(1'b0, 8'h00); settle();
    check("R6 edge EOI ppr", {24'd0, ppr}, 32'h0);
    check_dlv("R6 next pending offered", 1'b1, 8'h45);

    // R5 level requests
    do_req(8'h61, 1'b1); settle();
    check_dlv("R5 level request pending", 1'b1, 8'h61);
    do_req(8'h45, 1'b1);   // dropped: already pending
    do_ack(8'h61); settle();
    check("R4 ppr after level ack", {24'd0, ppr}, 32'h60);
    do_eoi(1'b1, 8'h61); settle();
    check_dlv("R6 after level EOI", 1'b1, 8'h45);
    do_ack(8'h45); settle();
    check("R4 ppr 45 in service", {24'd0, ppr}, 32'h40);
    check_dlv("R3 32 below ppr", 1'b0, 8'h00);
    do_eoi(1'b0, 8'h00); settle();   // R5: dropped level request left no trigger mode
    check_dlv("R5 dropped level req no tmr", 1'b1, 8'h32);

    // R6 nested service
    do_ack(8'h32); settle();
    check("R2 ppr 30", {24'd0, ppr}, 32'h30);
    do_req(8'h90, 1'b0); settle();
    check_dlv("R3 preempting vector", 1'b1, 8'h90);
    do_ack(8'h90); settle();
    check("R2 ppr 90", {24'd0, ppr}, 32'h90);
    do_tpr(32'h95); settle();
    check("R2 equal nibble keeps tpr", {24'd0, ppr}, 32'h95);
    do_tpr(32'h0); settle();
    do_eoi(1'b0, 8'h00); settle();
    check("R6 EOI retires highest", {24'd0, ppr}, 32'h30);
    do_eoi(1'b0, 8'h00); settle();
    check("R6 second EOI", {24'd0, ppr}, 32'h0);
    do_eoi(1'b0, 8'h00); settle();
    check("R6 empty EOI ignored ppr", {24'd0, ppr}, 32'h0);
    check_dlv("R1 nothing pending", 1'b0, 8'h00);

    // R8 timer coalescing
    do_fire(); do_fire(); do_fire(); settle();
    check_dlv("R8 timer pending", 1'b1, 8'h50);
    do_ack(8'h50); settle();
    check("R8 ppr timer", {24'd0, ppr}, 32'h50);
    do_eoi(1'b0, 8'h00); settle();
    check_dlv("R8 first re-pend", 1'b1, 8'h50);
    do_ack(8'h50); do_eoi(1'b0, 8'h00); settle();
    check_dlv("R8 second re-pend", 1'b1, 8'h50);
    do_ack(8'h50); do_eoi(1'b0, 8'h00); settle();
    check_dlv("R8 counter exhausted", 1'b0, 8'h00);

    // R9 disabled
    ctl_en = 1'b0;
    do_req(8'h70, 1'b0); do_fire(); settle();
    check_dlv("R9 no delivery while disabled", 1'b0, 8'h00);
    ctl_en = 1'b1;
    settle(); settle();
    check_dlv("R9 requests while disabled ignored", 1'b0, 8'h00);

    // R10 same-cycle request and acknowledge
    do_req(8'h88, 1'b0); settle();
    check_dlv("R10 setup", 1'b1, 8'h88);
    req_valid = 1'b1; req_vec = 8'h88; req_level = 1'b0;
    ack_valid = 1'b1; ack_vec = 8'h88;
    @(negedge clk);
    req_valid = 1'b0; ack_valid = 1'b0;
    settle();
    check("R10 in service", {24'd0, ppr}, 32'h80);
    do_eoi(1'b0, 8'h00); settle();
    check_dlv("R10 still pending", 1'b1, 8'h88);

    repeat (3) @(negedge clk);
    check("R6 all broadcasts seen", bc_q.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule